// File: doc/BRIEF.md
# Dual-Half DSP Address Generation Unit

This block computes data-memory addresses for a signal-processing core. It is built from two identical halves. Each half holds four register triplets. A triplet has an address register, an offset register and a modifier register. In any cycle, each half can post-modify one of its address registers. The step is +1, −1 or the triplet's offset. The half presents the address as it stood before the update as the effective address for that access.

The triplet's modifier register sets the arithmetic. The choices are plain binary addition, a circular buffer of arbitrary length, a power-of-two wrap window, or addition with the carry running from the most significant bit toward the least significant bit, as used for bit-reversed FFT addressing. Three 24-bit adders work in parallel on every update: a forward adder, a reversed-carry adder and a modulo-correction adder. The decoded modifier picks which of their results is stored.

Software loads and reads the registers through one port per half. An update request carries the triplet index and the operation code.

Top module: `dual_agu`

## Requirements
- R1: After reset, every address and offset register reads 0 and every modifier register reads 0xFFFFFF, which selects linear arithmetic.
- R2: With `wr_en` high, the field code `wr_field` chooses the register written at the next clock edge: 0 is the address, 1 is the offset, 2 is the modifier, and 3 writes nothing. The read port is combinational, uses the same field codes, and returns 0 for code 3.
- R3: While `upd_en` is high, `ea` shows the selected address register before the update. The updated value is visible from the next clock edge on.
- R4: The operation code `upd_op` selects the step: 0 holds the register, 1 adds one, 2 subtracts one, 3 adds the offset register read as a signed 24-bit value. An address register that is neither written nor updated keeps its value.
- R5: A modifier of 0xFFFFFF gives linear arithmetic: the new address is (address + step) modulo 2^24.
- R6: A modifier M from 1 to 0x7FFF gives a circular buffer of length M+1. P is the smallest power of two that is at least M+1. The base is the address with its low log2(P) bits cleared. A result above base+M wraps down by M+1, and a result below the base wraps up by M+1. This holds for any step whose size is at most M+1.
- R7: A modifier with bit 15 set, bits 23..16 clear and bits 14..0 equal to a power of two P gives a wrap window. The low log2(P) address bits take the low bits of address + step, and the bits above them stay as they were.
- R8: A modifier of 0 gives reverse-carry arithmetic: the address and the step are added with the carry moving from bit 23 toward bit 0.
- R9: If a load to an address register and an update of that same register occur in the same cycle, the loaded value is stored.
- R10: The two halves update independently and can both update in the same cycle. An update changes only the selected address register.
- R11: A modifier code that matches none of the patterns in R5 to R8 is treated as linear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NH | Load strobe, one bit per half |
| wr_field | input | NH x 2 | Register field to load, per half |
| wr_idx | input | NH x IW | Triplet index for the load, per half |
| wr_data | input | NH x AW | Load data, per half |
| rd_field | input | NH x 2 | Register field to read, per half |
| rd_idx | input | NH x IW | Triplet index for the read, per half |
| rd_data | output | NH x AW | Read data, combinational, per half |
| upd_en | input | NH | Update request, per half |
| upd_idx | input | NH x IW | Triplet index to update, per half |
| upd_op | input | NH x 2 | Update operation, per half |
| ea | output | NH x AW | Effective (pre-update) address, per half |

## Verification
The bench builds the block with its default parameters: 24-bit registers, four triplets and two halves, with the modulo field occupying bits 14..0 and bit 15 marking a wrap window. At this width the bench can step an address across the 24-bit rollover in linear mode. It can also walk a short circular buffer that is not a power of two through both its upper and lower wraps using +1, −1 and signed offsets. The width is also wide enough for a bit-reversed sequence to start in the most significant bit. With two halves, a same-cycle update on both halves is tested alongside a load/update collision on a single register.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_INC    = 2'd1,
    OP_DEC    = 2'd2,
    OP_ADDOFF = 2'd3
  } upd_op_e;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_OFF  = 2'd1,
    FLD_MOD  = 2'd2,
    FLD_NONE = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    MODE_LIN   = 2'd0,
    MODE_MOD   = 2'd1,
    MODE_MWRAP = 2'd2,
    MODE_REV   = 2'd3
  } arith_mode_e;

endpackage

// File: rtl/agu_mod_decode.sv
module agu_mod_decode
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int MB = 15
) (
  input  logic [AW-1:0] modifier,
  output arith_mode_e   mode,
  output logic [AW-1:0] wrap_mask,
  output logic [AW-1:0] span
);

  // Smallest all-ones mask covering v: P-1 for the smallest power of two P > v.
  function automatic logic [AW-1:0] fill_right(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int i = 1; i < AW; i++) r = r | (r >> 1);
    return r;
  endfunction

  logic [MB-1:0] low_field;
  logic [AW-1:0] low_ext;
  assign low_field = modifier[MB-1:0];
  assign low_ext   = {{(AW-MB){1'b0}}, low_field};

  always_comb begin
    mode      = MODE_LIN;
    wrap_mask = '0;
    span      = '0;
    if (&modifier) begin
      mode = MODE_LIN;
    end else if (modifier == '0) begin
      mode = MODE_REV;
    end else if (modifier[AW-1:MB] == '0) begin
      mode      = MODE_MOD;
      wrap_mask = fill_right(modifier);
      span      = modifier + 1'b1;
    end else if (modifier[AW-1:MB+1] == '0 && $countones(low_field) == 1) begin
      mode      = MODE_MWRAP;
      wrap_mask = low_ext - 1'b1;
      span      = low_ext;
    end
  end

endmodule

// File: rtl/agu_alu.sv
module agu_alu
  import agu_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] offset,
  input  logic [1:0]    op,
  input  arith_mode_e   mode,
  input  logic [AW-1:0] wrap_mask,
  input  logic [AW-1:0] span,
  output logic [AW-1:0] next_addr
);

  function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [AW-1:0] step;
  logic [AW-1:0] fwd_sum;
  logic [AW-1:0] rev_sum;
  logic [AW:0]   raw_low;
  logic [AW-1:0] fix_low;
  logic [AW-1:0] mod_low;
  logic [AW-1:0] mod_sum;
  logic [AW-1:0] mwrap_sum;
  logic          step_neg;
  logic          under;
  logic          over;
  logic [AW-1:0] picked;

  always_comb begin
    unique case (upd_op_e'(op))
      OP_INC:    step = {{(AW-1){1'b0}}, 1'b1};
      OP_DEC:    step = '1;
      OP_ADDOFF: step = offset;
      default:   step = '0;
    endcase
  end

  // Forward adder and reversed-carry adder share the same operands.
  assign fwd_sum = addr + step;
  assign rev_sum = bit_rev(bit_rev(addr) + bit_rev(step));

  // Modulo correction: add or subtract the buffer length when the
  // in-buffer offset leaves [0, span-1].
  assign step_neg = step[AW-1];
  assign raw_low  = {1'b0, addr & wrap_mask} + {step[AW-1], step};
  assign under    = step_neg & raw_low[AW];
  assign over     = ~step_neg & (raw_low >= {1'b0, span});
  assign fix_low  = step_neg ? raw_low[AW-1:0] + span : raw_low[AW-1:0] - span;
  assign mod_low  = (under | over) ? fix_low : raw_low[AW-1:0];
  assign mod_sum  = (addr & ~wrap_mask) | (mod_low & wrap_mask);

  assign mwrap_sum = (addr & ~wrap_mask) | (fwd_sum & wrap_mask);

  always_comb begin
    unique case (mode)
      MODE_MOD:   picked = mod_sum;
      MODE_MWRAP: picked = mwrap_sum;
      MODE_REV:   picked = rev_sum;
      default:    picked = fwd_sum;
    endcase
  end

  assign next_addr = (upd_op_e'(op) == OP_HOLD) ? addr : picked;

endmodule

// File: rtl/agu_half.sv
module agu_half
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int NT = 4,
  parameter int MB = 15,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_field,
  input  logic [IW-1:0]          wr_idx,
  input  logic [AW-1:0]          wr_data,
  input  logic [1:0]             rd_field,
  input  logic [IW-1:0]          rd_idx,
  output logic [AW-1:0]          rd_data,
  input  logic                   upd_en,
  input  logic [IW-1:0]          upd_idx,
  input  logic [1:0]             upd_op,
  output logic [AW-1:0]          ea,
  output logic [NT-1:0][AW-1:0]  addr_view,
  output logic [AW-1:0]          nxt_view,
  output logic                   load_wins,
  output logic [1:0]             mode_view,
  output logic [AW-1:0]          mask_view
);

  logic [NT-1:0][AW-1:0] addr_q;
  logic [NT-1:0][AW-1:0] off_q;
  logic [NT-1:0][AW-1:0] mod_q;

  logic [AW-1:0] cur_addr;
  logic [AW-1:0] cur_off;
  logic [AW-1:0] cur_mod;
  arith_mode_e   mode;
  logic [AW-1:0] wrap_mask;
  logic [AW-1:0] span;
  logic [AW-1:0] next_addr;

  assign cur_addr = addr_q[upd_idx];
  assign cur_off  = off_q[upd_idx];
  assign cur_mod  = mod_q[upd_idx];

  agu_mod_decode #(.AW(AW), .MB(MB)) u_dec (
    .modifier  (cur_mod),
    .mode      (mode),
    .wrap_mask (wrap_mask),
    .span      (span)
  );

  agu_alu #(.AW(AW)) u_alu (
    .addr      (addr_q[upd_idx]),
    .offset    (cur_off),
    .op        (upd_op),
    .mode      (mode),
    .wrap_mask (wrap_mask),
    .span      (span),
    .next_addr (next_addr)
  );

  for (genvar t = 0; t < NT; t++) begin : g_trip
    logic wr_hit;
    logic up_hit;
    assign wr_hit = wr_en && (wr_idx == IW'(t));
    assign up_hit = upd_en && (upd_idx == IW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[t] <= '0;
        off_q[t]  <= '0;
        mod_q[t]  <= '1;
      end else begin
        if (wr_hit && field_e'(wr_field) == FLD_ADDR) addr_q[t] <= wr_data;
        else if (up_hit)                              addr_q[t] <= next_addr;
        if (wr_hit && field_e'(wr_field) == FLD_OFF)  off_q[t]  <= wr_data;
        if (wr_hit && field_e'(wr_field) == FLD_MOD)  mod_q[t]  <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (field_e'(rd_field))
      FLD_ADDR: rd_data = addr_q[rd_idx];
      FLD_OFF:  rd_data = off_q[rd_idx];
      FLD_MOD:  rd_data = mod_q[rd_idx];
      default:  rd_data = '0;
    endcase
  end

  assign ea        = cur_addr;
  assign addr_view = addr_q;
  assign nxt_view  = next_addr;
  assign load_wins = wr_en && upd_en && field_e'(wr_field) == FLD_ADDR && wr_idx == upd_idx;
  assign mode_view = mode;
  assign mask_view = wrap_mask;

endmodule

// File: rtl/dual_agu.sv
module dual_agu
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int NT = 4,
  parameter int NH = 2,
  parameter int MB = 15,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NH-1:0]         wr_en,
  input  logic [NH-1:0][1:0]    wr_field,
  input  logic [NH-1:0][IW-1:0] wr_idx,
  input  logic [NH-1:0][AW-1:0] wr_data,
  input  logic [NH-1:0][1:0]    rd_field,
  input  logic [NH-1:0][IW-1:0] rd_idx,
  output logic [NH-1:0][AW-1:0] rd_data,
  input  logic [NH-1:0]         upd_en,
  input  logic [NH-1:0][IW-1:0] upd_idx,
  input  logic [NH-1:0][1:0]    upd_op,
  output logic [NH-1:0][AW-1:0] ea
);

  logic [NH-1:0][NT-1:0][AW-1:0] addr_all;
  logic [NH-1:0][AW-1:0]         nxt_all;
  logic [NH-1:0]                 wins_all;
  logic [NH-1:0][1:0]            mode_all;
  logic [NH-1:0][AW-1:0]         mask_all;

  for (genvar h = 0; h < NH; h++) begin : g_half
    agu_half #(.AW(AW), .NT(NT), .MB(MB), .IW(IW)) u_half (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en[h]),
      .wr_field  (wr_field[h]),
      .wr_idx    (wr_idx[h]),
      .wr_data   (wr_data[h]),
      .rd_field  (rd_field[h]),
      .rd_idx    (rd_idx[h]),
      .rd_data   (rd_data[h]),
      .upd_en    (upd_en[h]),
      .upd_idx   (upd_idx[h]),
      .upd_op    (upd_op[h]),
      .ea        (ea[h]),
      .addr_view (addr_all[h]),
      .nxt_view  (nxt_all[h]),
      .load_wins (wins_all[h]),
      .mode_view (mode_all[h]),
      .mask_view (mask_all[h])
    );
  end

endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int AW = 24,
  parameter int NT = 4,
  parameter int NH = 2,
  parameter int IW = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NH-1:0]                 wr_en,
  input logic [NH-1:0][IW-1:0]         wr_idx,
  input logic [NH-1:0][AW-1:0]         wr_data,
  input logic [NH-1:0]                 upd_en,
  input logic [NH-1:0][IW-1:0]         upd_idx,
  input logic [NH-1:0][1:0]            upd_op,
  input logic [NH-1:0][AW-1:0]         ea,
  input logic [NH-1:0][NT-1:0][AW-1:0] addr_all,
  input logic [NH-1:0][AW-1:0]         nxt_all,
  input logic [NH-1:0]                 wins_all,
  input logic [NH-1:0][1:0]            mode_all,
  input logic [NH-1:0][AW-1:0]         mask_all
);

  for (genvar h = 0; h < NH; h++) begin : g_chk
    AST_UPDATE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en[h] && !wins_all[h]) |=> addr_all[h][$past(upd_idx[h])] == $past(nxt_all[h])); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wins_all[h] |=> addr_all[h][$past(wr_idx[h])] == $past(wr_data[h])); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en[h] && !wr_en[h]) |=> $stable(addr_all[h])); // R4

    AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en[h] && upd_op[h] == 2'd0) |-> nxt_all[h] == ea[h]); // R4

    AST_MOD_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en[h] && mode_all[h] == MODE_MOD) |-> (nxt_all[h] & ~mask_all[h]) == (ea[h] & ~mask_all[h])); // R6

    AST_MWRAP_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en[h] && mode_all[h] == MODE_MWRAP) |-> (nxt_all[h] & ~mask_all[h]) == (ea[h] & ~mask_all[h])); // R7
  end

endmodule

bind dual_agu agu_checker #(.AW(AW), .NT(NT), .NH(NH), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .upd_en   (upd_en),
  .upd_idx  (upd_idx),
  .upd_op   (upd_op),
  .ea       (ea),
  .addr_all (addr_all),
  .nxt_all  (nxt_all),
  .wins_all (wins_all),
  .mode_all (mode_all),
  .mask_all (mask_all)
);

// File: tb/dual_agu_bench.sv
`timescale 1ns/1ps
module dual_agu_bench;

  localparam int AW = 24;
  localparam int NT = 4;
  localparam int NH = 2;
  localparam int IW = 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NH-1:0]         wr_en = '0;
  logic [NH-1:0][1:0]    wr_field = '0;
  logic [NH-1:0][IW-1:0] wr_idx = '0;
  logic [NH-1:0][AW-1:0] wr_data = '0;
  logic [NH-1:0][1:0]    rd_field = '0;
  logic [NH-1:0][IW-1:0] rd_idx = '0;
  logic [NH-1:0][AW-1:0] rd_data;
  logic [NH-1:0]         upd_en = '0;
  logic [NH-1:0][IW-1:0] upd_idx = '0;
  logic [NH-1:0][1:0]    upd_op = '0;
  logic [NH-1:0][AW-1:0] ea;

  always #2 clk = ~clk;  // 250 MHz

  dual_agu u_dual_agu (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_field(wr_field), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_field(rd_field), .rd_idx(rd_idx), .rd_data(rd_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_op(upd_op), .ea(ea)
  );

  typedef struct {
    int          cyc;
    int          kind;  // 0: ea, 1: rd_data
    int          h;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [23:0] ma[NH][NT];
  logic [23:0] mo[NH][NT];
  logic [23:0] mm[NH][NT];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations in the cycle they fall due.
  item_t       mon_it;
  logic [23:0] mon_got;
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      mon_it  = sbq.pop_front();
      mon_got = (mon_it.kind == 0) ? ea[mon_it.h] : rd_data[mon_it.h];
      checks++;
      if (mon_it.cyc != cyc || mon_got !== mon_it.exp) begin
        fails++;
        $display("FAIL %s half%0d kind%0d actual=%06h expected=%06h", mon_it.tag,
                 mon_it.h, mon_it.kind, mon_got, mon_it.exp);
      end
    end
  end

  function automatic void push(int c, int k, int h, logic [23:0] e, string tag);
    item_t it;
    it.cyc = c; it.kind = k; it.h = h; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endfunction

  // Reference model, written from the requirements.
  function automatic logic [23:0] model_next(logic [23:0] a, logic [23:0] o,
                                             logic [23:0] m, logic [1:0] op);
    int          s;
    logic [23:0] sv;
    int          sz, p, base, n;
    logic [23:0] r;
    int          c;
    if (op == 2'd0) return a;
    s  = (op == 2'd1) ? 1 : (op == 2'd2) ? -1 : ((o[23]) ? int'(o) - 16777216 : int'(o));
    sv = 24'(s);
    if (m == 24'h0) begin
      c = 0;
      for (int i = 23; i >= 0; i--) begin
        n = int'(a[i]) + int'(sv[i]) + c;
        r[i] = n[0];
        c = n >>> 1;
      end
      return r;
    end
    if (m <= 24'h7FFF) begin
      sz = int'(m) + 1;
      p = 1;
      while (p < sz) p = p * 2;
      base = int'(a) - (int'(a) % p);
      n = int'(a) - base + s;
      if (n > int'(m)) n = n - sz;
      if (n < 0) n = n + sz;
      return 24'(base + n);
    end
    if (m[23:16] == 8'h0 && m[15] && $countones(m[14:0]) == 1) begin
      p = int'(m[14:0]);
      base = int'(a) - (int'(a) % p);
      n = (int'(a) % p) + s;
      while (n < 0) n = n + p;
      n = n % p;
      return 24'(base + n);
    end
    return 24'(int'(a) + s);
  endfunction

  task automatic step_clk();
    @(posedge clk); #1;
  endtask

  task automatic load(int h, logic [1:0] f, logic [1:0] idx, logic [23:0] v);
    wr_en[h] = 1'b1; wr_field[h] = f; wr_idx[h] = idx; wr_data[h] = v;
    step_clk();
    wr_en[h] = 1'b0;
    if (f == 2'd0) ma[h][idx] = v;
    else if (f == 2'd1) mo[h][idx] = v;
    else if (f == 2'd2) mm[h][idx] = v;
  endtask

  task automatic rd_chk(int h, logic [1:0] f, logic [1:0] idx, logic [23:0] e, string tag);
    rd_field[h] = f; rd_idx[h] = idx;
    push(cyc, 1, h, e, tag);
    step_clk();
  endtask

  task automatic upd(int h, logic [1:0] idx, logic [1:0] op, string tag);
    logic [23:0] nx;
    nx = model_next(ma[h][idx], mo[h][idx], mm[h][idx], op);
    upd_en[h] = 1'b1; upd_idx[h] = idx; upd_op[h] = op;
    rd_field[h] = 2'd0; rd_idx[h] = idx;
    push(cyc, 0, h, ma[h][idx], tag);
    push(cyc + 1, 1, h, nx, tag);
    step_clk();
    upd_en[h] = 1'b0;
    ma[h][idx] = nx;
    step_clk();
  endtask

  task automatic dual(logic [1:0] i0, logic [1:0] op0, logic [1:0] i1, logic [1:0] op1);
    logic [23:0] n0, n1;
    n0 = model_next(ma[0][i0], mo[0][i0], mm[0][i0], op0);
    n1 = model_next(ma[1][i1], mo[1][i1], mm[1][i1], op1);
    upd_en = 2'b11; upd_idx[0] = i0; upd_idx[1] = i1; upd_op[0] = op0; upd_op[1] = op1;
    rd_field = '0; rd_idx[0] = i0; rd_idx[1] = i1;
    push(cyc, 0, 0, ma[0][i0], "R10 ea0");
    push(cyc, 0, 1, ma[1][i1], "R10 ea1");
    push(cyc + 1, 1, 0, n0, "R10 new0");
    push(cyc + 1, 1, 1, n1, "R10 new1");
    step_clk();
    upd_en = '0;
    ma[0][i0] = n0; ma[1][i1] = n1;
    step_clk();
  endtask

  task automatic collide(int h, logic [1:0] idx, logic [23:0] v);
    wr_en[h] = 1'b1; wr_field[h] = 2'd0; wr_idx[h] = idx; wr_data[h] = v;
    upd_en[h] = 1'b1; upd_idx[h] = idx; upd_op[h] = 2'd1;
    rd_field[h] = 2'd0; rd_idx[h] = idx;
    push(cyc, 0, h, ma[h][idx], "R9 ea");
    push(cyc + 1, 1, h, v, "R9 load wins");
    step_clk();
    wr_en[h] = 1'b0; upd_en[h] = 1'b0;
    ma[h][idx] = v;
    step_clk();
  endtask

  initial begin
    for (int h = 0; h < NH; h++)
      for (int t = 0; t < NT; t++) begin
        ma[h][t] = '0; mo[h][t] = '0; mm[h][t] = '1;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step_clk();

    // R1 reset values
    rd_chk(0, 2'd0, 2'd0, 24'h0, "R1 addr");
    rd_chk(1, 2'd2, 2'd3, 24'hFFFFFF, "R1 modifier");
    rd_chk(0, 2'd1, 2'd2, 24'h0, "R1 offset");

    // R2 load and read by field
    load(0, 2'd1, 2'd0, 24'h000010);
    rd_chk(0, 2'd1, 2'd0, 24'h000010, "R2 offset load");
    load(0, 2'd3, 2'd0, 24'h123456);
    rd_chk(0, 2'd3, 2'd0, 24'h0, "R2 field3 reads zero");
    rd_chk(0, 2'd0, 2'd0, 24'h0, "R2 field3 writes nothing");

    // R5 linear with rollover, R4 operations
    load(0, 2'd0, 2'd0, 24'hFFFFFE);
    upd(0, 2'd0, 2'd1, "R5 inc");
    upd(0, 2'd0, 2'd1, "R5 rollover");
    upd(0, 2'd0, 2'd3, "R4 add offset");
    upd(0, 2'd0, 2'd2, "R4 dec");
    upd(0, 2'd0, 2'd0, "R4 hold");

    // R6 circular buffer of length 5
    load(0, 2'd2, 2'd1, 24'h000004);
    load(0, 2'd0, 2'd1, 24'h000103);
    upd(0, 2'd1, 2'd1, "R6 inc");
    upd(0, 2'd1, 2'd1, "R6 upper wrap");
    upd(0, 2'd1, 2'd2, "R6 lower wrap");
    load(0, 2'd1, 2'd1, 24'h000003);
    upd(0, 2'd1, 2'd3, "R6 offset wrap");
    load(0, 2'd1, 2'd1, 24'hFFFFFE);
    upd(0, 2'd1, 2'd3, "R6 neg offset");
    upd(0, 2'd1, 2'd3, "R6 neg offset wrap");

    // R7 wrap window of 16
    load(1, 2'd2, 2'd2, 24'h008010);
    load(1, 2'd0, 2'd2, 24'h00003E);
    load(1, 2'd1, 2'd2, 24'h000005);
    upd(1, 2'd2, 2'd3, "R7 offset wrap");
    load(1, 2'd0, 2'd2, 24'h000030);
    upd(1, 2'd2, 2'd2, "R7 dec wrap");

    // R8 reverse carry
    load(1, 2'd2, 2'd3, 24'h000000);
    load(1, 2'd1, 2'd3, 24'h800000);
    upd(1, 2'd3, 2'd3, "R8 rev1");
    upd(1, 2'd3, 2'd3, "R8 rev2");
    upd(1, 2'd3, 2'd3, "R8 rev3");
    upd(1, 2'd3, 2'd1, "R8 rev inc");

    // R11 reserved codes behave as linear
    load(0, 2'd2, 2'd3, 24'h010000);
    load(0, 2'd0, 2'd3, 24'h007FFF);
    upd(0, 2'd3, 2'd1, "R11 reserved high");
    load(0, 2'd2, 2'd3, 24'h008003);
    upd(0, 2'd3, 2'd2, "R11 reserved non-pow2");

    // R9 load beats update
    load(1, 2'd0, 2'd0, 24'h000005);
    collide(1, 2'd0, 24'hABCDEF);

    // R10 both halves at once, others untouched
    dual(2'd2, 2'd1, 2'd1, 2'd2);
    rd_chk(0, 2'd0, 2'd0, ma[0][0], "R10 other triplet addr");
    rd_chk(1, 2'd0, 2'd2, ma[1][2], "R10 other half addr");
    rd_chk(1, 2'd1, 2'd1, mo[1][1], "R10 offset untouched");

    repeat (3) step_clk();
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule